// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer with Early Warning

This block is a memory-mapped watchdog for a system chip. Software talks to it over a small 16-bit register bus with a byte address, a write strobe, a read strobe and data in both directions. A slow reference clock is brought into the bus clock domain by a short synchroniser. Every `PRESCALE` rising edges of that clock make one countdown unit, nominally 10 ms. The countdown is reloaded from a 15-bit timeout value. One unit before it runs out, an early-warning event is raised. When it runs out, a reset pulse goes to the system reset controller.

The block does nothing on an ordinary register write. Each control action needs its own exact 16-bit key: feeding, resuming from the disabled state, clearing the trip status and both halves of the two-step disable sequence. A write with any other value is dropped. The trip status is sticky and reads back as a coded word, so it survives the reset the block causes. An interrupt event bit can be masked and can be forced. A debugger-override control decides whether the countdown halts while a debug-mode input is high.

Top module: `wdog_keyed_top`

## Requirements
- R1: Out of reset the watchdog is disabled, so offset 0x0C reads 0xDABE. Offset 0x10 reads 0x0000, offsets 0x24, 0x28 and 0x20 read 0, offset 0x04 reads `TMO_INIT`, the count reads 0, and both `irq` and `sys_rst_out` are low.
- R2: Writing 0xACED to offset 0x1C leaves the disabled state, after which 0x0C reads 0x0000. Any other value written there is ignored.
- R3: While the watchdog is enabled, writing 0xFEED to offset 0x00 loads the count from the timeout register (offset 0x04, bits 14:0) and starts the countdown. The write is ignored while disabled or when any other value is written.
- R4: While running, the count at offset 0x14 bits 14:0 goes down by one on every `PRESCALE`-th synchronised rising edge of `slow_clk`.
- R5: A countdown unit that finds the count at 1 or 0 trips the watchdog. `sys_rst_out` goes high for `RST_CYCLES` bus clocks, offset 0x10 reads 0xCFE8, and the count reloads from the timeout and keeps running.
- R6: The trip status returns to 0x0000 only when 0xE8B4 is written to offset 0x10. Other values leave it unchanged.
- R7: Writing 0x2BAD to 0x08 and then, as the very next bus write, 0xCAFE to 0x0C disables the watchdog. A 0xCAFE write without that preceding write is ignored. While disabled the count is frozen.
- R8: Bit 0 of offset 0x20 sets when a countdown unit takes the count from 2 to 1. Writing 1 to that bit clears it. `irq` is high exactly when that bit and bit 0 of offset 0x24 are both 1.
- R9: While bit 0 of offset 0x28 is 1, the event bit is held set and an acknowledge cannot clear it.
- R10: Offset 0x18 reads `dbg_mode` in bit 1 and the override control in bit 0. While `dbg_mode` is high and the override bit is 0, the countdown halts. With the override bit set, it keeps counting.
- R11: Bit 15 of offset 0x14 is 1 while a `slow_clk` transition is still inside the synchroniser (the count may be about to change), and 0 otherwise.
- R12: In a single cycle, a feed beats a countdown unit (the count equals the timeout afterwards). A trip beats a status clear (the status stays 0xCFE8). A new early-warning event beats an acknowledge (the event stays set).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| slow_clk | input | 1 | Slow reference clock, asynchronous |
| dbg_mode | input | 1 | High while a debugger holds the system |
| bus_addr | input | 6 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq | output | 1 | Early-warning interrupt |
| sys_rst_out | output | 1 | Reset request pulse on a trip |

## Verification
Three pairs of functions can land on the same clock edge: a feed with a countdown unit, a status clear with a trip, and an event acknowledge with a new early warning. The bench steers each pair onto one edge by waiting until its reference model predicts that the next edge carries a countdown unit, then issuing the bus write in that same half cycle. The result is read back through the registers: the count must equal the timeout, the status must still read tripped, and the event bit must still be set.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DATA_W = 16;
    localparam int CNT_W  = DATA_W - 1;
    localparam int ADDR_W = 6;

    // Register offsets: software-visible, so fixed
    localparam logic [ADDR_W-1:0] A_FEED   = 6'h00;
    localparam logic [ADDR_W-1:0] A_TMO    = 6'h04;
    localparam logic [ADDR_W-1:0] A_DIS1   = 6'h08;
    localparam logic [ADDR_W-1:0] A_DIS2   = 6'h0C;
    localparam logic [ADDR_W-1:0] A_STAT   = 6'h10;
    localparam logic [ADDR_W-1:0] A_CNT    = 6'h14;
    localparam logic [ADDR_W-1:0] A_DBG    = 6'h18;
    localparam logic [ADDR_W-1:0] A_RESUME = 6'h1C;
    localparam logic [ADDR_W-1:0] A_EVT    = 6'h20;
    localparam logic [ADDR_W-1:0] A_MASK   = 6'h24;
    localparam logic [ADDR_W-1:0] A_FORCE  = 6'h28;

    // Action keys and coded read values
    localparam logic [DATA_W-1:0] K_FEED   = 16'hFEED;
    localparam logic [DATA_W-1:0] K_DIS1   = 16'h2BAD;
    localparam logic [DATA_W-1:0] K_DIS2   = 16'hCAFE;
    localparam logic [DATA_W-1:0] K_RESUME = 16'hACED;
    localparam logic [DATA_W-1:0] K_CLR    = 16'hE8B4;
    localparam logic [DATA_W-1:0] V_OFF    = 16'hDABE;
    localparam logic [DATA_W-1:0] V_TRIP   = 16'hCFE8;

    // One decoded bus write, at most one action bit set besides any_wr
    typedef struct packed {
        logic any_wr;
        logic feed;
        logic dis1;
        logic dis2;
        logic resume;
        logic clr;
        logic tmo_we;
        logic dbg_we;
        logic ack;
        logic mask_we;
        logic force_we;
    } wdog_cmd_t;

    function automatic wdog_cmd_t decode_write(
        input logic              wr,
        input logic [ADDR_W-1:0] a,
        input logic [DATA_W-1:0] d
    );
        wdog_cmd_t c;
        c          = '0;
        c.any_wr   = wr;
        c.feed     = wr && a == A_FEED   && d == K_FEED;
        c.dis1     = wr && a == A_DIS1   && d == K_DIS1;
        c.dis2     = wr && a == A_DIS2   && d == K_DIS2;
        c.resume   = wr && a == A_RESUME && d == K_RESUME;
        c.clr      = wr && a == A_STAT   && d == K_CLR;
        c.tmo_we   = wr && a == A_TMO;
        c.dbg_we   = wr && a == A_DBG;
        c.ack      = wr && a == A_EVT    && d[0];
        c.mask_we  = wr && a == A_MASK;
        c.force_we = wr && a == A_FORCE;
        return c;
    endfunction

endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen
    import wdog_pkg::*;
#(
    parameter int PRESCALE = 320
) (
    input  logic clk,
    input  logic rst,
    input  logic slow_clk,
    input  logic run,
    input  logic clr,
    output logic unit_tick,
    output logic unsettled
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PMAX = PW'(PRESCALE - 1);

    logic [2:0]    sync_q;
    logic [PW-1:0] pre_q;
    logic          edge_seen;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], slow_clk};
    end

    assign edge_seen = sync_q[1] && !sync_q[2];
    assign unsettled = sync_q[0] ^ sync_q[2];
    assign unit_tick = edge_seen && run && (pre_q == PMAX);

    always_ff @(posedge clk) begin
        if (rst || clr)           pre_q <= '0;
        else if (edge_seen && run) pre_q <= (pre_q == PMAX) ? '0 : pre_q + 1'b1;
    end
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int RST_CYCLES = 16,
    parameter int TMO_INIT   = 6000
) (
    input  logic             clk,
    input  logic             rst,
    input  wdog_cmd_t        cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic             dbg_mode,
    input  logic             unit_tick,
    output logic             en,
    output logic             run,
    output logic             feed_ok,
    output logic             armed,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] tmo,
    output logic             sticky,
    output logic             ovr,
    output logic             prebark,
    output logic             sys_rst_out
);
    localparam int RW = $clog2(RST_CYCLES + 1);

    logic          started;
    logic          dis_ok;
    logic          counting;
    logic          trip;
    logic [RW-1:0] rcnt;

    assign dis_ok   = cmd.dis2 && armed;
    assign feed_ok  = cmd.feed && en;
    assign run      = en && started && (!dbg_mode || ovr);
    assign counting = unit_tick && !dis_ok && !feed_ok;
    assign trip     = counting && (cnt <= CNT_W'(1));
    assign prebark  = counting && (cnt == CNT_W'(2));
    assign sys_rst_out = (rcnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            en      <= 1'b0;
            started <= 1'b0;
            cnt     <= '0;
        end else begin
            if (dis_ok) begin
                en      <= 1'b0;
                started <= 1'b0;
            end else if (cmd.resume) begin
                en      <= 1'b1;
            end
            if (feed_ok && !dis_ok) begin
                cnt     <= tmo;
                started <= 1'b1;
            end else if (trip) begin
                cnt     <= tmo;
            end else if (counting) begin
                cnt     <= cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmo    <= CNT_W'(TMO_INIT);
            ovr    <= 1'b0;
            armed  <= 1'b0;
            sticky <= 1'b0;
            rcnt   <= '0;
        end else begin
            if (cmd.tmo_we) tmo <= wdata[CNT_W-1:0];
            if (cmd.dbg_we) ovr <= wdata[0];
            if (cmd.dis1)        armed <= 1'b1;
            else if (cmd.any_wr) armed <= 1'b0;
            if (trip)          sticky <= 1'b1;
            else if (cmd.clr)  sticky <= 1'b0;
            if (trip)               rcnt <= RW'(RST_CYCLES);
            else if (rcnt != '0)    rcnt <= rcnt - 1'b1;
        end
    end
endmodule

// File: rtl/wdog_irq.sv
module wdog_irq
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wdog_cmd_t         cmd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              prebark,
    output logic              evt,
    output logic              mask,
    output logic              force_q,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            evt     <= 1'b0;
            mask    <= 1'b0;
            force_q <= 1'b0;
        end else begin
            if (force_q || prebark) evt <= 1'b1;
            else if (cmd.ack)       evt <= 1'b0;
            if (cmd.mask_we)  mask    <= wdata[0];
            if (cmd.force_we) force_q <= wdata[0];
        end
    end

    assign irq = evt && mask;
endmodule

// File: rtl/wdog_keyed_top.sv
module wdog_keyed_top
    import wdog_pkg::*;
#(
    parameter int PRESCALE   = 320,
    parameter int RST_CYCLES = 16,
    parameter int TMO_INIT   = 6000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slow_clk,
    input  logic              dbg_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              sys_rst_out
);
    wdog_cmd_t        cmd;
    logic             unit_tick, unsettled;
    logic             en, run, feed_ok, armed, sticky, ovr, prebark;
    logic             evt, mask, force_q;
    logic [CNT_W-1:0] cnt, tmo;
    logic [DATA_W-1:0] rmux;

    assign cmd = decode_write(bus_wr, bus_addr, bus_wdata);

    wdog_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk(clk), .rst(rst), .slow_clk(slow_clk), .run(run), .clr(feed_ok),
        .unit_tick(unit_tick), .unsettled(unsettled)
    );

    wdog_core #(.RST_CYCLES(RST_CYCLES), .TMO_INIT(TMO_INIT)) u_core (
        .clk(clk), .rst(rst), .cmd(cmd), .wdata(bus_wdata), .dbg_mode(dbg_mode),
        .unit_tick(unit_tick), .en(en), .run(run), .feed_ok(feed_ok),
        .armed(armed), .cnt(cnt), .tmo(tmo), .sticky(sticky), .ovr(ovr),
        .prebark(prebark), .sys_rst_out(sys_rst_out)
    );

    wdog_irq u_irq (
        .clk(clk), .rst(rst), .cmd(cmd), .wdata(bus_wdata), .prebark(prebark),
        .evt(evt), .mask(mask), .force_q(force_q), .irq(irq)
    );

    always_comb begin
        rmux = '0;
        case (bus_addr)
            A_TMO:   rmux = {1'b0, tmo};
            A_DIS2:  rmux = en ? '0 : V_OFF;
            A_STAT:  rmux = sticky ? V_TRIP : '0;
            A_CNT:   rmux = {unsettled, cnt};
            A_DBG:   rmux = {{(DATA_W-2){1'b0}}, dbg_mode, ovr};
            A_EVT:   rmux = {{(DATA_W-1){1'b0}}, evt};
            A_MASK:  rmux = {{(DATA_W-1){1'b0}}, mask};
            A_FORCE: rmux = {{(DATA_W-1){1'b0}}, force_q};
            default: rmux = '0;
        endcase
    end

    assign bus_rdata = bus_rd ? rmux : '0;
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk
    import wdog_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              dbg_mode,
    input logic              sys_rst_out,
    input logic              en_q,
    input logic              armed_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              sticky_q,
    input logic              ovr_q,
    input logic              force_q,
    input logic              evt_q
);
    p_frozen_when_off_r7: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> $stable(cnt_q));

    p_stray_step2_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_DIS2 && bus_wdata == K_DIS2 && !armed_q && en_q) |=> en_q);

    p_trip_marks_status_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_rst_out) |-> sticky_q);

    p_status_key_only_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(sticky_q) |-> $past(bus_wr && bus_addr == A_STAT && bus_wdata == K_CLR));

    p_force_holds_r9: assert property (@(posedge clk) disable iff (rst)
        force_q |=> evt_q);

    p_debug_halt_r10: assert property (@(posedge clk) disable iff (rst)
        (dbg_mode && !ovr_q && !(bus_wr && bus_addr == A_FEED)) |=> $stable(cnt_q));
endmodule

bind wdog_keyed_top wdog_keyed_chk u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .dbg_mode(dbg_mode), .sys_rst_out(sys_rst_out),
    .en_q(en), .armed_q(armed), .cnt_q(cnt), .sticky_q(sticky),
    .ovr_q(ovr), .force_q(force_q), .evt_q(evt)
);

// File: tb/tb_wdog_keyed_top.sv
module tb_wdog_keyed_top;
    localparam int PRE  = 4;
    localparam int RSTC = 5;
    localparam int TINI = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_clk = 1'b0;
    logic        dbg_mode = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq, sys_rst_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    wdog_keyed_top #(.PRESCALE(PRE), .RST_CYCLES(RSTC), .TMO_INIT(TINI)) dut (
        .clk(clk), .rst(rst), .slow_clk(slow_clk), .dbg_mode(dbg_mode),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .sys_rst_out(sys_rst_out)
    );

    always #4 clk = ~clk;

    // slow reference clock: toggles every 6 bus clocks
    int sdiv = 0;
    always @(negedge clk) begin
        sdiv <= (sdiv == 5) ? 0 : sdiv + 1;
        if (sdiv == 5) slow_clk <= ~slow_clk;
    end

    // ---------------- behavioural reference model ----------------
    bit m_s1, m_s2, m_s3, m_en, m_started, m_arm, m_sticky, m_ovr;
    bit m_evt, m_mask, m_force;
    int m_pre, m_cnt, m_tmo, m_rcnt;

    function automatic bit m_running();
        return m_en && m_started && (!dbg_mode || m_ovr);
    endfunction

    function automatic bit m_unit_next();
        return m_s2 && !m_s3 && m_running() && m_pre == PRE - 1;
    endfunction

    always @(posedge clk) begin
        bit tick, run, feed, dis, unit, expire, pb;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_en = 0; m_started = 0; m_arm = 0;
            m_sticky = 0; m_ovr = 0; m_evt = 0; m_mask = 0; m_force = 0;
            m_pre = 0; m_cnt = 0; m_tmo = TINI; m_rcnt = 0;
        end else begin
            tick = m_s2 && !m_s3;
            run  = m_running();
            feed = bus_wr && bus_addr == 6'h00 && bus_wdata == 16'hFEED && m_en;
            dis  = bus_wr && bus_addr == 6'h0C && bus_wdata == 16'hCAFE && m_arm;
            unit = tick && run && m_pre == PRE - 1;
            expire = 0; pb = 0;
            if (feed) m_pre = 0;
            else if (tick && run) m_pre = (m_pre == PRE - 1) ? 0 : m_pre + 1;
            if (dis) begin
                m_en = 0; m_started = 0;
            end else begin
                if (feed) begin
                    m_cnt = m_tmo; m_started = 1;
                end else if (unit) begin
                    if (m_cnt <= 1) begin expire = 1; m_cnt = m_tmo; end
                    else begin pb = (m_cnt == 2); m_cnt = m_cnt - 1; end
                end
                if (bus_wr && bus_addr == 6'h1C && bus_wdata == 16'hACED) m_en = 1;
            end
            if (expire) m_rcnt = RSTC;
            else if (m_rcnt > 0) m_rcnt = m_rcnt - 1;
            if (expire) m_sticky = 1;
            else if (bus_wr && bus_addr == 6'h10 && bus_wdata == 16'hE8B4) m_sticky = 0;
            if (bus_wr && bus_addr == 6'h08 && bus_wdata == 16'h2BAD) m_arm = 1;
            else if (bus_wr) m_arm = 0;
            if (m_force || pb) m_evt = 1;
            else if (bus_wr && bus_addr == 6'h20 && bus_wdata[0]) m_evt = 0;
            if (bus_wr && bus_addr == 6'h04) m_tmo = int'(bus_wdata[14:0]);
            if (bus_wr && bus_addr == 6'h18) m_ovr = bus_wdata[0];
            if (bus_wr && bus_addr == 6'h24) m_mask = bus_wdata[0];
            if (bus_wr && bus_addr == 6'h28) m_force = bus_wdata[0];
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = slow_clk;
        end
    end

    function automatic logic [15:0] m_read(input logic [5:0] a);
        case (a)
            6'h04: return 16'(m_tmo);
            6'h0C: return m_en ? 16'h0000 : 16'hDABE;
            6'h10: return m_sticky ? 16'hCFE8 : 16'h0000;
            6'h14: return {(m_s1 ^ m_s3), 15'(m_cnt)};
            6'h18: return {14'b0, dbg_mode, m_ovr};
            6'h20: return {15'b0, m_evt};
            6'h24: return {15'b0, m_mask};
            6'h28: return {15'b0, m_force};
            default: return 16'h0000;
        endcase
    endfunction

    // ---------------- checking helpers ----------------
    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // per-clock comparison of the outputs (R5 reset pulse, R8 interrupt)
    always @(negedge clk) begin
        if (!rst) begin
            chk("R5 sys_rst_out", {15'b0, sys_rst_out}, {15'b0, m_rcnt != 0});
            chk("R8 irq", {15'b0, irq}, {15'b0, m_evt && m_mask});
        end
    end

    task automatic rd(input logic [5:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(tag, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    task automatic rdm(input logic [5:0] a, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(tag, bus_rdata, m_read(a));
        bus_rd = 1'b0;
    endtask

    task automatic wr_now(input logic [5:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_now(a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // watchdog on the bench itself
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    logic [15:0] held;

    initial begin
        idle(3);
        rst = 1'b0;
        // R1 reset state
        rd(6'h0C, 16'hDABE, "R1 disabled");
        rd(6'h10, 16'h0000, "R1 status");
        rd(6'h24, 16'h0000, "R1 mask");
        rd(6'h28, 16'h0000, "R1 force");
        rd(6'h20, 16'h0000, "R1 event");
        rd(6'h04, 16'(TINI), "R1 timeout");
        rdm(6'h14, "R1 count");

        // R3 feed ignored while disabled; R2 wrong resume key ignored
        wr(6'h00, 16'hFEED);
        rdm(6'h14, "R3 feed while off");
        wr(6'h1C, 16'h1234);
        rd(6'h0C, 16'hDABE, "R2 bad resume key");
        wr(6'h1C, 16'hACED);
        rd(6'h0C, 16'h0000, "R2 resume key");

        // R3 feed with wrong and right key
        wr(6'h04, 16'd5);
        wr(6'h00, 16'hFEEE);
        rd(6'h14, 16'h0000, "R3 bad feed key");
        wr(6'h00, 16'hFEED);
        rd(6'h14, 16'h0005, "R3 feed loads timeout");

        // R4 countdown
        idle(100);
        rdm(6'h14, "R4 count after two units");
        idle(30);
        rdm(6'h14, "R4 count later");

        // R8 early warning, masked interrupt, acknowledge
        wr(6'h24, 16'h0001);
        while (!m_evt) @(negedge clk);
        rd(6'h20, 16'h0001, "R8 event set");
        wr(6'h20, 16'h0001);
        rd(6'h20, 16'h0000, "R8 event acked");

        // R5 trip, R6 status clear by key only
        while (m_rcnt == 0) @(negedge clk);
        idle(RSTC + 2);
        rd(6'h10, 16'hCFE8, "R5 status tripped");
        rdm(6'h14, "R5 reloaded count");
        wr(6'h10, 16'h1111);
        rd(6'h10, 16'hCFE8, "R6 bad clear key");
        wr(6'h10, 16'hE8B4);
        rd(6'h10, 16'h0000, "R6 clear key");

        // R9 force holds the event
        wr(6'h28, 16'h0001);
        idle(2);
        wr(6'h20, 16'h0001);
        rd(6'h20, 16'h0001, "R9 ack under force");
        wr(6'h28, 16'h0000);
        wr(6'h20, 16'h0001);
        rd(6'h20, 16'h0000, "R9 ack after force off");

        // R12 feed beats a countdown unit
        wr(6'h04, 16'd6);
        wr(6'h00, 16'hFEED);
        do @(negedge clk); while (!m_unit_next());
        wr_now(6'h00, 16'hFEED);
        rd(6'h14, 16'h0006, "R12 feed over tick");

        // R12 trip beats a clear
        do @(negedge clk); while (!(m_unit_next() && m_cnt <= 1));
        wr_now(6'h10, 16'hE8B4);
        rd(6'h10, 16'hCFE8, "R12 trip over clear");

        // R12 early warning beats an acknowledge
        do @(negedge clk); while (!(m_unit_next() && m_cnt == 2));
        wr_now(6'h20, 16'h0001);
        rd(6'h20, 16'h0001, "R12 event over ack");
        wr(6'h20, 16'h0001);

        // R11 synchroniser-in-flight flag
        do @(negedge clk); while (!(m_s1 ^ m_s3));
        bus_addr = 6'h14; bus_rd = 1'b1; #1;
        chk("R11 unsettled flag", {15'b0, bus_rdata[15]}, 16'h0001);
        bus_rd = 1'b0;
        do @(negedge clk); while (m_s1 ^ m_s3);
        bus_addr = 6'h14; bus_rd = 1'b1; #1;
        chk("R11 settled flag", {15'b0, bus_rdata[15]}, 16'h0000);
        bus_rd = 1'b0;

        // R10 debug halt and override
        @(negedge clk); dbg_mode = 1'b1;
        rd(6'h18, 16'h0002, "R10 debug visible");
        @(negedge clk); held = {1'b0, bus_rdata[14:0]};
        bus_addr = 6'h14; bus_rd = 1'b1; #1; held = {1'b0, bus_rdata[14:0]}; bus_rd = 1'b0;
        idle(150);
        bus_addr = 6'h14; bus_rd = 1'b1; #1;
        chk("R10 halted in debug", {1'b0, bus_rdata[14:0]}, held);
        bus_rd = 1'b0;
        wr(6'h18, 16'h0001);
        rd(6'h18, 16'h0003, "R10 override set");
        idle(150);
        rdm(6'h14, "R10 counting with override");
        @(negedge clk); dbg_mode = 1'b0;
        wr(6'h18, 16'h0000);

        // R7 disable sequence
        wr(6'h08, 16'h2BAD);
        wr(6'h04, 16'd6);
        wr(6'h0C, 16'hCAFE);
        rd(6'h0C, 16'h0000, "R7 broken sequence");
        wr(6'h0C, 16'hCAFE);
        rd(6'h0C, 16'h0000, "R7 step2 alone");
        wr(6'h08, 16'h2BAD);
        wr(6'h0C, 16'hCAFE);
        rd(6'h0C, 16'hDABE, "R7 disabled");
        @(negedge clk);
        bus_addr = 6'h14; bus_rd = 1'b1; #1; held = {1'b0, bus_rdata[14:0]}; bus_rd = 1'b0;
        idle(150);
        bus_addr = 6'h14; bus_rd = 1'b1; #1;
        chk("R7 frozen while off", {1'b0, bus_rdata[14:0]}, held);
        bus_rd = 1'b0;
        rdm(6'h14, "R7 model count");

        idle(5);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule